// File: doc/BRIEF.md
# Channel Command Chaining Sequencer

This block carries out one channel program on behalf of a single device. A `start` pulse makes it read the address word at byte 72 of memory. That word gives the 4-bit protection key used for every data store and the location of the first 8-byte command word. The sequencer then walks the command list. It accepts bytes from a device byte stream and stores them at ascending memory addresses.

Flag bits in each command word control how the walk proceeds:
- One record can be spread over several memory areas.
- Bytes can be counted off without being stored.
- A further device operation can follow without an interrupt in between.
- The walk can jump to another place in the list.
- An early interrupt request can be raised.
- A length mismatch between record and count can be reported or ignored.

When the program ends, a four-byte status word is stored at byte 64 and a one-cycle interrupt pulse is raised.

Memory reads use a word port with a fixed one-cycle latency: data appears on the cycle after the request is sampled. Writes use a byte port that carries the protection key. Each new device operation is announced with a one-cycle command strobe.

Top module: `ccs_sequencer`

## Requirements
- R1: While reset is held, and afterwards until `start`, the outputs `rd_en`, `wr_en`, `dv_ready`, `dev_op_valid`, `pci_irq` and `irq` are all 0.
- R2: The address word is read from byte 72, numbering bits 0 (most significant) to 31. Bits 0-3 are the key placed on every data write, and bits 8-31 give the first command address. Non-zero bits 4-7 end the program with no data stored and with status flag byte 0x40.
- R3: A command word is read as two big-endian words: bits 0-7 are the command, bits 8-31 the data address, bits 32-36 the flags and bits 48-63 the byte count. Bits 40-47 are ignored. Each accepted device byte, while the count is non-zero, is written to the current data address; the address then rises by one and the count falls by one.
- R4: Chain-data is flag bit 32. When the count reaches zero with this flag set, the next word at command address + 8 is fetched and the same record continues into the new area. The command byte of that word is ignored, so no command strobe is issued.
- R5: Skip is flag bit 35. While it is set, accepted bytes reduce the count but nothing is written.
- R6: Chain-command is flag bit 33. After a record ends with no length error reported, the word at command address + 8 starts a new device operation, announced on `dev_op_valid` and `dev_op`. Only one `irq` pulse is raised for the whole chain.
- R7: A command whose low four bits are 1000 is a jump. The next word is fetched from the jump's data address, and its bits 32-63 are ignored. A jump whose target is also a jump ends the program with status flag byte 0x40.
- R8: A record is ended by `dv_last`. If the bytes received differ from the count, status flag 0x80 is set and any chain-command is dropped. This does not apply when flag bit 34 (suppress length) of the word in use is set. Bytes beyond the count are accepted but not stored.
- R9: Each non-jump word with flag bit 36 set raises a one-cycle `pci_irq` pulse, and the operation continues.
- R10: At the end, four bytes are written most-significant first to bytes 64-67 with key 0. The first byte holds the flags (0x80 length error, 0x40 program check). The other three bytes hold the address of the last command word used, plus 8. `irq` pulses for one cycle after the last status byte.
- R11: A non-jump word with any of bits 37-39 set ends the program with status flag byte 0x40, without starting the operation or storing data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| start | input | 1 | begin a channel program (pulse, honoured when idle) |
| rd_en | output | 1 | word read request |
| rd_addr | output | 24 | byte address of the word read |
| rd_data | input | 32 | read data, valid one cycle after the request is sampled |
| wr_en | output | 1 | byte write strobe |
| wr_addr | output | 24 | byte write address |
| wr_data | output | 8 | byte write data |
| wr_key | output | 4 | protection key of the write |
| dv_valid | input | 1 | device byte present |
| dv_data | input | 8 | device byte |
| dv_last | input | 1 | byte closes the record |
| dv_ready | output | 1 | sequencer accepts a byte this cycle |
| dev_op_valid | output | 1 | strobe: a new device operation begins |
| dev_op | output | 8 | command of that operation |
| pci_irq | output | 1 | early interrupt request pulse |
| irq | output | 1 | end-of-program interrupt pulse |

## Verification
The bench splits one record over three command words, one of them skipping. A sequencer that let the skip leak would store bytes, and one that decoded the chained command byte would announce a second operation. Short and long records are run with and without the suppress flag. A wrong length rule would show up as a missing or spurious 0x80 flag, stored excess bytes, or a chain-command followed despite an error. Jump chains, a jump to a jump, and bad zero fields in both the address word and a command word are run as well. Each must produce the exact status address and flag and no data stores.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  localparam int CCS_AW = 24;  // memory byte address width
  localparam int CCS_CW = 16;  // byte count width
  localparam int CCS_KW = 4;   // protection key width

  typedef enum logic [3:0] {
    S_IDLE, S_CAWW, S_CAWD, S_CW1, S_CW2, S_CW3, S_XFER, S_STAT, S_IRQ
  } ccs_state_e;

  typedef struct packed {
    logic [7:0]        cmd;
    logic [CCS_AW-1:0] daddr;
    logic              cd;
    logic              cc;
    logic              sli;
    logic              skip;
    logic              pci;
    logic              bad;
    logic              tic;
    logic [CCS_CW-1:0] cnt;
  } ccs_cw_t;
endpackage

// File: rtl/ccs_cw_decode.sv
module ccs_cw_decode
  import ccs_pkg::*;
(
  input  logic [31:0] w0,
  input  logic [31:0] w1,
  output ccs_cw_t     cw
);
  logic unused_bits;
  assign unused_bits = ^w1[23:16];

  always_comb begin
    cw.cmd   = w0[31:24];
    cw.daddr = w0[CCS_AW-1:0];
    cw.cd    = w1[31];
    cw.cc    = w1[30];
    cw.sli   = w1[29];
    cw.skip  = w1[28];
    cw.pci   = w1[27];
    cw.bad   = |w1[26:24];
    cw.tic   = (w0[27:24] == 4'b1000);
    cw.cnt   = w1[CCS_CW-1:0];
  end
endmodule

// File: rtl/ccs_xfer_ctr.sv
module ccs_xfer_ctr #(
  parameter int AW = 24,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic [CW-1:0] ld_cnt,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      cnt  <= '0;
    end else if (load) begin
      addr <= ld_addr;
      cnt  <= ld_cnt;
    end else if (step) begin
      addr <= addr + AW'(1);
      cnt  <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/ccs_sequencer.sv
module ccs_sequencer
  import ccs_pkg::*;
#(
  parameter int CAW_LOC  = 72,
  parameter int STAT_LOC = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              rd_en,
  output logic [CCS_AW-1:0] rd_addr,
  input  logic [31:0]       rd_data,
  output logic              wr_en,
  output logic [CCS_AW-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic [CCS_KW-1:0] wr_key,
  input  logic              dv_valid,
  input  logic [7:0]        dv_data,
  input  logic              dv_last,
  output logic              dv_ready,
  output logic              dev_op_valid,
  output logic [7:0]        dev_op,
  output logic              pci_irq,
  output logic              irq
);
  localparam logic [CCS_AW-1:0] CW_STEP = CCS_AW'(8);

  ccs_state_e        state;
  logic [CCS_KW-1:0] key;
  logic [CCS_AW-1:0] ccw_addr;
  logic [31:0]       w0;
  logic              new_op, tic_prev;
  logic              f_cd, f_cc, f_sli, f_skip;
  logic [1:0]        st_flags;  // [1] length error, [0] program check
  logic [1:0]        sidx;
  logic [31:0]       st_word;

  ccs_cw_t           cw;
  logic [CCS_AW-1:0] daddr;
  logic [CCS_CW-1:0] cnt;
  logic              accept, ctr_load, ctr_step, cnt_zero;

  ccs_cw_decode u_dec (.w0(w0), .w1(rd_data), .cw(cw));

  assign cnt_zero = (cnt == '0);
  assign dv_ready = (state == S_XFER) && !(cnt_zero && f_cd);
  assign accept   = dv_valid && dv_ready;
  assign ctr_load = (state == S_CW3) && !cw.tic && !cw.bad;
  assign ctr_step = accept && !cnt_zero;
  assign st_word  = {st_flags, 6'b0, ccw_addr + CW_STEP};

  ccs_xfer_ctr #(.AW(CCS_AW), .CW(CCS_CW)) u_ctr (
    .clk(clk), .rst(rst), .load(ctr_load), .ld_addr(cw.daddr),
    .ld_cnt(cw.cnt), .step(ctr_step), .addr(daddr), .cnt(cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; key <= '0; ccw_addr <= '0; w0 <= '0;
      new_op <= 1'b0; tic_prev <= 1'b0;
      f_cd <= 1'b0; f_cc <= 1'b0; f_sli <= 1'b0; f_skip <= 1'b0;
      st_flags <= '0; sidx <= '0;
      rd_en <= 1'b0; rd_addr <= '0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0; wr_key <= '0;
      dev_op_valid <= 1'b0; dev_op <= '0; pci_irq <= 1'b0; irq <= 1'b0;
    end else begin
      rd_en <= 1'b0; wr_en <= 1'b0; dev_op_valid <= 1'b0;
      pci_irq <= 1'b0; irq <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          rd_en <= 1'b1; rd_addr <= CCS_AW'(CAW_LOC);
          new_op <= 1'b1; tic_prev <= 1'b0; st_flags <= '0;
          state <= S_CAWW;
        end
        S_CAWW: state <= S_CAWD;
        S_CAWD: begin
          key      <= rd_data[31:28];
          ccw_addr <= rd_data[CCS_AW-1:0];
          if (rd_data[27:24] != 4'b0) begin
            st_flags <= 2'b01; sidx <= '0; state <= S_STAT;
          end else begin
            rd_en <= 1'b1; rd_addr <= rd_data[CCS_AW-1:0]; state <= S_CW1;
          end
        end
        S_CW1: begin
          rd_en <= 1'b1; rd_addr <= ccw_addr + CCS_AW'(4); state <= S_CW2;
        end
        S_CW2: begin
          w0 <= rd_data; state <= S_CW3;
        end
        S_CW3: begin
          if (cw.tic) begin
            if (tic_prev) begin
              st_flags <= 2'b01; sidx <= '0; state <= S_STAT;
            end else begin
              tic_prev <= 1'b1; ccw_addr <= cw.daddr;
              rd_en <= 1'b1; rd_addr <= cw.daddr; state <= S_CW1;
            end
          end else if (cw.bad) begin
            st_flags <= 2'b01; sidx <= '0; state <= S_STAT;
          end else begin
            tic_prev <= 1'b0;
            f_cd <= cw.cd; f_cc <= cw.cc; f_sli <= cw.sli; f_skip <= cw.skip;
            if (new_op) begin
              dev_op_valid <= 1'b1; dev_op <= cw.cmd; new_op <= 1'b0;
            end
            if (cw.pci) pci_irq <= 1'b1;
            state <= S_XFER;
          end
        end
        S_XFER: begin
          if (cnt_zero && f_cd) begin
            ccw_addr <= ccw_addr + CW_STEP;
            rd_en <= 1'b1; rd_addr <= ccw_addr + CW_STEP; state <= S_CW1;
          end else if (accept) begin
            if (!cnt_zero && !f_skip) begin
              wr_en <= 1'b1; wr_addr <= daddr; wr_data <= dv_data; wr_key <= key;
            end
            if (dv_last) begin
              if ((cnt != CCS_CW'(1)) && !f_sli) begin
                st_flags <= 2'b10; sidx <= '0; state <= S_STAT;
              end else if (f_cc) begin
                new_op <= 1'b1; ccw_addr <= ccw_addr + CW_STEP;
                rd_en <= 1'b1; rd_addr <= ccw_addr + CW_STEP; state <= S_CW1;
              end else begin
                sidx <= '0; state <= S_STAT;
              end
            end
          end
        end
        S_STAT: begin
          wr_en   <= 1'b1;
          wr_addr <= CCS_AW'(STAT_LOC) + CCS_AW'(sidx);
          wr_data <= st_word[31 - 8*sidx -: 8];
          wr_key  <= '0;
          sidx    <= sidx + 2'd1;
          if (sidx == 2'd3) state <= S_IRQ;
        end
        S_IRQ: begin
          irq <= 1'b1; state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ccs_checker.sv
module ccs_checker #(
  parameter int AW       = 24,
  parameter int STAT_LOC = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_en,
  input logic          dv_ready,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          dev_op_valid,
  input logic          pci_irq,
  input logic          irq
);
  // R1: memory reads and byte acceptance belong to separate phases
  a_r1_read_apart_from_stream: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && dv_ready));

  // R10: the end interrupt is a single-cycle pulse
  a_r10_irq_one_cycle: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R10: the interrupt follows directly on the last status byte
  a_r10_status_then_irq: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(wr_en && (wr_addr == AW'(STAT_LOC + 3))));

  // R9: early request never coincides with the end interrupt
  a_r9_pci_apart_from_irq: assert property (@(posedge clk) disable iff (rst)
    !(pci_irq && irq));

  // R6: each device operation is announced by a single-cycle strobe
  a_r6_op_strobe_one_cycle: assert property (@(posedge clk) disable iff (rst)
    dev_op_valid |=> !dev_op_valid);
endmodule

bind ccs_sequencer ccs_checker #(.AW(ccs_pkg::CCS_AW), .STAT_LOC(STAT_LOC)) u_ccs_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .dv_ready(dv_ready), .wr_en(wr_en),
  .wr_addr(wr_addr), .dev_op_valid(dev_op_valid), .pci_irq(pci_irq), .irq(irq)
);

// File: tb/test_ccs_sequencer.sv
`timescale 1ns/1ps
module test_ccs_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        rd_en, wr_en, dv_ready, dev_op_valid, pci_irq, irq;
  logic [23:0] rd_addr, wr_addr;
  logic [31:0] rd_data = '0;
  logic [7:0]  wr_data, dev_op;
  logic [3:0]  wr_key;
  logic        dv_valid = 1'b0, dv_last = 1'b0;
  logic [7:0]  dv_data = '0;

  always #10 clk = ~clk;  // 50 MHz

  ccs_sequencer i_ccs_sequencer (
    .clk(clk), .rst(rst), .start(start),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_key(wr_key),
    .dv_valid(dv_valid), .dv_data(dv_data), .dv_last(dv_last), .dv_ready(dv_ready),
    .dev_op_valid(dev_op_valid), .dev_op(dev_op), .pci_irq(pci_irq), .irq(irq)
  );

  logic [7:0] mem [0:1023];
  always @(posedge clk)
    if (rd_en)
      rd_data <= {mem[rd_addr[9:0]], mem[rd_addr[9:0] + 10'd1],
                  mem[rd_addr[9:0] + 10'd2], mem[rd_addr[9:0] + 10'd3]};

  int compared = 0, mismatched = 0;
  int pci_cnt = 0, irq_cnt = 0;
  logic [35:0] exp_q [$];
  string       tag_q [$];
  logic [7:0]  op_q  [$];
  bit          done = 0;

  localparam logic [4:0] F_CD = 5'b10000, F_CC = 5'b01000, F_SLI = 5'b00100,
                         F_SKIP = 5'b00010, F_PCI = 5'b00001;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected items as the design produces them
  always @(negedge clk) if (!rst) begin
    if (wr_en) begin
      if (exp_q.size() == 0) begin
        chk(0, "R3", "unexpected write", int'({wr_addr, wr_data}), 0);
      end else begin
        logic [35:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({wr_addr, wr_data, wr_key} === e, t, "write addr/data/key",
            int'({wr_addr, wr_data, wr_key}), int'(e));
      end
    end
    if (dev_op_valid) begin
      if (op_q.size() == 0) chk(0, "R4", "unexpected device operation", dev_op, 0);
      else begin
        logic [7:0] o;
        o = op_q.pop_front();
        chk(dev_op === o, "R6", "device command", dev_op, o);
      end
    end
    if (pci_irq) pci_cnt++;
    if (irq) irq_cnt++;
  end

  task automatic put_word(input int a, input logic [31:0] w);
    for (int i = 0; i < 4; i++) mem[a + i] = w[31 - 8*i -: 8];
  endtask

  task automatic put_cw(input int a, input logic [7:0] cmd, input logic [23:0] da,
                        input logic [4:0] fl, input logic [15:0] n);
    put_word(a, {cmd, da});
    put_word(a + 4, {fl, 3'b000, 8'hA5, n});
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
  endtask

  task automatic exp_wr(input logic [23:0] a, input logic [7:0] d, input logic [3:0] k,
                        input string t);
    exp_q.push_back({a, d, k});
    tag_q.push_back(t);
  endtask

  task automatic exp_stat(input logic [7:0] fl, input logic [23:0] a, input string t);
    exp_wr(24'd64, fl, 4'h0, t);
    exp_wr(24'd65, a[23:16], 4'h0, t);
    exp_wr(24'd66, a[15:8], 4'h0, t);
    exp_wr(24'd67, a[7:0], 4'h0, t);
  endtask

  task automatic send_rec(input logic [7:0] b0, input int n);
    for (int i = 0; i < n; ) begin
      @(negedge clk);
      dv_valid = 1'b1;
      dv_data  = b0 + 8'(i);
      dv_last  = (i == n - 1);
      #1;
      if (dv_ready) i++;
    end
    @(negedge clk);
    dv_valid = 1'b0;
    dv_last  = 1'b0;
  endtask

  task automatic kick();
    pci_cnt = 0;
    irq_cnt = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_op(input string t, input int pcis);
    while (!irq) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, t, "expected writes left", exp_q.size(), 0);
    chk(op_q.size() == 0, t, "device operations left", op_q.size(), 0);
    chk(irq_cnt == 1, "R10", "interrupt pulses", irq_cnt, 1);
    chk(pci_cnt == pcis, "R9", "early requests", pci_cnt, pcis);
    exp_q.delete();
    tag_q.delete();
    op_q.delete();
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not complete");
      report();
    end
  end

  initial begin
    clear_mem();
    repeat (4) @(negedge clk);
    // R1: idle outputs during reset
    chk({rd_en, wr_en, dv_ready, dev_op_valid, pci_irq, irq} == 6'b0, "R1",
        "outputs in reset", int'({rd_en, wr_en, dv_ready, dev_op_valid, pci_irq, irq}), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk({rd_en, wr_en, dv_ready, dev_op_valid, pci_irq, irq} == 6'b0, "R1",
        "outputs idle after reset", int'({rd_en, wr_en, dv_ready, dev_op_valid, pci_irq, irq}), 0);

    // R2 R3: plain read of 4 bytes with key 5
    clear_mem();
    put_word(72, 32'h5000_0100);
    put_cw(32'h100, 8'h02, 24'h200, 5'b0, 16'd4);
    for (int i = 0; i < 4; i++) exp_wr(24'h200 + 24'(i), 8'h60 + 8'(i), 4'h5, "R3");
    exp_stat(8'h00, 24'h108, "R10");
    op_q.push_back(8'h02);
    kick();
    send_rec(8'h60, 4);
    finish_op("R3", 0);

    // R8: short record, length error reported
    clear_mem();
    put_word(72, 32'h5000_0100);
    put_cw(32'h100, 8'h02, 24'h200, 5'b0, 16'd5);
    for (int i = 0; i < 3; i++) exp_wr(24'h200 + 24'(i), 8'h20 + 8'(i), 4'h5, "R8");
    exp_stat(8'h80, 24'h108, "R8");
    op_q.push_back(8'h02);
    kick();
    send_rec(8'h20, 3);
    finish_op("R8", 0);

    // R8: long record, suppress flag, excess bytes discarded
    clear_mem();
    put_word(72, 32'h5000_0100);
    put_cw(32'h100, 8'h02, 24'h200, F_SLI, 16'd4);
    for (int i = 0; i < 4; i++) exp_wr(24'h200 + 24'(i), 8'h30 + 8'(i), 4'h5, "R8");
    exp_stat(8'h00, 24'h108, "R8");
    op_q.push_back(8'h02);
    kick();
    send_rec(8'h30, 6);
    finish_op("R8", 0);

    // R4 R5: one record over three words, middle one skipping
    clear_mem();
    put_word(72, 32'h7000_0100);
    put_cw(32'h100, 8'h02, 24'h200, F_CD, 16'd2);
    put_cw(32'h108, 8'h0F, 24'h250, F_CD | F_SKIP, 16'd2);
    put_cw(32'h110, 8'h05, 24'h300, 5'b0, 16'd2);
    exp_wr(24'h200, 8'h10, 4'h7, "R4");
    exp_wr(24'h201, 8'h11, 4'h7, "R4");
    exp_wr(24'h300, 8'h14, 4'h7, "R5");
    exp_wr(24'h301, 8'h15, 4'h7, "R5");
    exp_stat(8'h00, 24'h118, "R4");
    op_q.push_back(8'h02);
    kick();
    send_rec(8'h10, 6);
    finish_op("R4", 0);

    // R6 R7 R9: command chain through a jump, second op with early request
    clear_mem();
    put_word(72, 32'h3000_0100);
    put_cw(32'h100, 8'h01, 24'h200, F_CC, 16'd1);
    put_word(32'h108, 32'h0800_0180);
    put_word(32'h10C, 32'hFFFF_FFFF);
    put_cw(32'h180, 8'h02, 24'h210, F_PCI, 16'd1);
    exp_wr(24'h200, 8'h40, 4'h3, "R6");
    exp_wr(24'h210, 8'h50, 4'h3, "R7");
    exp_stat(8'h00, 24'h188, "R7");
    op_q.push_back(8'h01);
    op_q.push_back(8'h02);
    kick();
    send_rec(8'h40, 1);
    send_rec(8'h50, 1);
    finish_op("R6", 1);

    // R8: length error drops a pending chain-command
    clear_mem();
    put_word(72, 32'h2000_0100);
    put_cw(32'h100, 8'h01, 24'h200, F_CC, 16'd2);
    put_cw(32'h108, 8'h02, 24'h220, 5'b0, 16'd1);
    exp_wr(24'h200, 8'h70, 4'h2, "R8");
    exp_stat(8'h80, 24'h108, "R8");
    op_q.push_back(8'h01);
    kick();
    send_rec(8'h70, 1);
    finish_op("R8", 0);

    // R7: jump to a jump
    clear_mem();
    put_word(72, 32'h1000_0100);
    put_word(32'h100, 32'h0800_0120);
    put_word(32'h120, 32'h1800_0100);
    exp_stat(8'h40, 24'h128, "R7");
    kick();
    finish_op("R7", 0);

    // R2: bad address word bits 4-7
    clear_mem();
    put_word(72, 32'h5100_0100);
    exp_stat(8'h40, 24'h108, "R2");
    kick();
    finish_op("R2", 0);

    // R11: bad bits 37-39 in a command word
    clear_mem();
    put_word(72, 32'h5000_0100);
    put_word(32'h100, 32'h0200_0200);
    put_word(32'h104, {5'b0, 3'b010, 8'h00, 16'd4});
    exp_stat(8'h40, 24'h108, "R11");
    kick();
    finish_op("R11", 0);

    done = 1;
    report();
  end
endmodule